// File: doc/BRIEF.md
# Bus and Timer Clock-Enable Divider

This block sits next to the system clock and turns the prescaler settings of a bus configuration word into single-cycle clock-enable pulses. The pulses serve five domains: one high-speed bus, two peripheral buses and two timer domains, one timer domain per peripheral bus. Logic in each domain stays on the system clock and advances only on cycles where its enable is high. The effective rate of a domain is therefore the system clock rate divided by two raised to the domain's shift.

The prescaler codes do not map linearly onto divide ratios. The high-speed code has no divide-by-32 setting. Each peripheral bus rate comes straight from the system clock and is not affected by the high-speed setting. Each timer domain runs at two or four times its peripheral bus rate, chosen by a global timer mode bit, and falls back to the system clock or the high-speed bus clock when the bus divide is small. A new setting never cuts a period short: every lane holds its current divide until the period in progress ends. The decoded shift of every domain is also brought out so that the rates can be observed.

Top module: `clkdiv_top`

## Requirements
- R1: The high-speed shift comes from `busCfg[7:4]`. Codes 0 to 7 give shift 0. Codes 8, 9, 10, 11, 12, 13, 14 and 15 give shifts 1, 2, 3, 4, 6, 7, 8 and 9, so shift 5 never appears.
- R2: Peripheral bus A takes its code from `busCfg[12:10]` and bus B from `busCfg[15:13]`. Codes 0 to 3 give shift 0 and codes 4 to 7 give shifts 1 to 4. These shifts do not depend on the high-speed code.
- R3: With `timMode` low, a timer shift is 0 when its bus shift is 0 and one less than its bus shift otherwise, which is twice the bus rate.
- R4: With `timMode` high, a timer shift equals the high-speed shift when its bus shift is 0, 1 or 2, and is its bus shift minus 2 otherwise, which is four times the bus rate.
- R5: Each enable is high for exactly one cycle in every 2^shift cycles of its lane. A lane with shift 0 keeps its enable high on every cycle.
- R6: When a setting changes, a lane keeps its current period until its next pulse. The cycle after that pulse begins a period of the new length, so no interval between pulses is shortened.
- R7: During reset all lane counters are zero and all enables are high. On the first cycle after reset is released every enable pulses, and all lanes restart from that common point.
- R8: Changing the high-speed code alone leaves the peripheral bus enable pattern unchanged, and leaves the timer enable pattern unchanged as long as `timMode` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busCfg | input | 16 | Bus prescaler configuration word (fields at 7:4, 12:10, 15:13) |
| timMode | input | 1 | Timer rate mode: 0 selects twice the bus rate, 1 selects four times the bus rate |
| hsEn | output | 1 | High-speed bus clock enable |
| pbEn | output | 2 | Peripheral bus enables, bit 0 bus A, bit 1 bus B |
| timEn | output | 2 | Timer domain enables, bit 0 follows bus A, bit 1 follows bus B |
| hsShift | output | 4 | Decoded high-speed shift |
| pbShiftA | output | 3 | Decoded peripheral bus A shift |
| pbShiftB | output | 3 | Decoded peripheral bus B shift |
| tmShiftA | output | 4 | Decoded timer A shift |
| tmShiftB | output | 4 | Decoded timer B shift |

## Verification
The assertions assume that `busCfg` and `timMode` are synchronous to `clk` and settle well before each rising edge. Under that assumption the decoded shifts seen at an edge are the ones each lane loads at its boundary. They also assume that every bit pattern of the fields is legal, so no property excludes a code. To meet these assumptions, the stimulus changes inputs only just after the falling edge and sweeps every high-speed and bus code under both timer modes. It also changes settings partway through long periods and applies reset while lanes are mid-count.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  // configuration word layout
  localparam int CFG_W      = 16;
  localparam int HS_LSB     = 4;
  localparam int HS_CW      = 4;
  localparam int PB_LSB     = 10;
  localparam int PB_CW      = 3;
  localparam int NUM_PB     = 2;
  // shift and counter sizing
  localparam int MAX_SHIFT  = 9;
  localparam int SHIFT_W    = 4;
  localparam int PB_SHIFT_W = 3;
  localparam int CNT_W      = MAX_SHIFT;
  localparam int LANES      = 1 + 2 * NUM_PB;

  typedef struct packed {
    logic [SHIFT_W-1:0]                 hs;
    logic [NUM_PB-1:0][PB_SHIFT_W-1:0] pb;
    logic [NUM_PB-1:0][SHIFT_W-1:0]    tm;
  } divPlan_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic [CFG_W-1:0] busCfg,
  input  logic             timMode,
  output divPlan_t         plan
);
  logic unusedBits;
  assign unusedBits = ^{busCfg[HS_LSB-1:0], busCfg[PB_LSB-1:HS_LSB+HS_CW]};

  function automatic logic [SHIFT_W-1:0] hsDecode(input logic [HS_CW-1:0] code);
    logic [2:0] low;
    low = code[2:0];
    if (!code[HS_CW-1]) return '0;
    // step over shift 5 for the upper half of the codes
    if (low < 3'd4) return SHIFT_W'(low) + SHIFT_W'(1);
    return SHIFT_W'(low) + SHIFT_W'(2);
  endfunction

  function automatic logic [PB_SHIFT_W-1:0] pbDecode(input logic [PB_CW-1:0] code);
    if (!code[PB_CW-1]) return '0;
    return PB_SHIFT_W'(code[PB_CW-2:0]) + PB_SHIFT_W'(1);
  endfunction

  function automatic logic [SHIFT_W-1:0] tmDecode(input logic [PB_SHIFT_W-1:0] pb,
                                                  input logic [SHIFT_W-1:0] hs,
                                                  input logic mode);
    logic [SHIFT_W-1:0] pbw;
    pbw = SHIFT_W'(pb);
    if (mode) begin
      if (pbw <= SHIFT_W'(2)) return hs;
      return pbw - SHIFT_W'(2);
    end
    if (pbw == '0) return '0;
    return pbw - SHIFT_W'(1);
  endfunction

  assign plan.hs = hsDecode(busCfg[HS_LSB +: HS_CW]);

  for (genvar p = 0; p < NUM_PB; p++) begin : g_bus
    assign plan.pb[p] = pbDecode(busCfg[PB_LSB + p*PB_CW +: PB_CW]);
    assign plan.tm[p] = tmDecode(plan.pb[p], plan.hs, timMode);
  end
endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane #(
  parameter int SW = 4,
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [SW-1:0] shift,
  output logic          en
);
  logic [CW-1:0] cnt;
  logic [CW:0]   span;
  logic [CW-1:0] reload;

  assign span   = (CW+1)'(1) << shift;
  assign reload = CW'(span - (CW+1)'(1));
  assign en     = (cnt == '0);

  // the period is sampled only at a boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)   cnt <= '0;
    else if (en) cnt <= reload;
    else         cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  divPlan_t         plan,
  output logic [LANES-1:0] en
);
  logic [LANES-1:0][SHIFT_W-1:0] laneShift;

  assign laneShift[0] = plan.hs;
  for (genvar p = 0; p < NUM_PB; p++) begin : g_map
    assign laneShift[1 + p]          = SHIFT_W'(plan.pb[p]);
    assign laneShift[1 + NUM_PB + p] = plan.tm[p];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    clkdiv_lane #(.SW(SHIFT_W), .CW(CNT_W)) lane_i (
      .clk   (clk),
      .rstN  (rstN),
      .shift (laneShift[l]),
      .en    (en[l])
    );
  end
endmodule

// File: rtl/clkdiv_top.sv
module clkdiv_top
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CFG_W-1:0]  busCfg,
  input  logic              timMode,
  output logic              hsEn,
  output logic [NUM_PB-1:0] pbEn,
  output logic [NUM_PB-1:0] timEn,
  output logic [SHIFT_W-1:0]    hsShift,
  output logic [PB_SHIFT_W-1:0] pbShiftA,
  output logic [PB_SHIFT_W-1:0] pbShiftB,
  output logic [SHIFT_W-1:0]    tmShiftA,
  output logic [SHIFT_W-1:0]    tmShiftB
);
  divPlan_t         plan;
  logic [LANES-1:0] laneEn;

  clkdiv_ctrl ctrl_i (
    .busCfg  (busCfg),
    .timMode (timMode),
    .plan    (plan)
  );

  clkdiv_bank bank_i (
    .clk  (clk),
    .rstN (rstN),
    .plan (plan),
    .en   (laneEn)
  );

  assign hsEn     = laneEn[0];
  assign pbEn     = laneEn[NUM_PB:1];
  assign timEn    = laneEn[2*NUM_PB:NUM_PB+1];
  assign hsShift  = plan.hs;
  assign pbShiftA = plan.pb[0];
  assign pbShiftB = plan.pb[1];
  assign tmShiftA = plan.tm[0];
  assign tmShiftB = plan.tm[1];
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk (
  input logic       clk,
  input logic       rstN,
  input logic       timMode,
  input logic       hsEn,
  input logic [1:0] pbEn,
  input logic [3:0] hsShift,
  input logic [2:0] pbShiftA,
  input logic [2:0] pbShiftB,
  input logic [3:0] tmShiftA
);
  // R1
  hs_shift_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    hsShift != 4'd5 && hsShift <= 4'd9);

  // R2
  pb_shift_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    pbShiftA <= 3'd4 && pbShiftB <= 3'd4);

  // R3
  tm_slow_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timMode && pbShiftA != 3'd0) |-> ({1'b0, pbShiftA} == tmShiftA + 4'd1));

  // R4
  tm_fast_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (timMode && pbShiftA <= 3'd2) |-> (tmShiftA == hsShift));

  // R5
  hs_pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsEn && hsShift != 4'd0) |=> !hsEn);

  // R5
  hs_div1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hsEn && hsShift == 4'd0) |=> hsEn);

  // R5
  pb_pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pbEn[0] && pbShiftA != 3'd0) |=> !pbEn[0]);
endmodule

bind clkdiv_top clkdiv_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .timMode  (timMode),
  .hsEn     (hsEn),
  .pbEn     (pbEn),
  .hsShift  (hsShift),
  .pbShiftA (pbShiftA),
  .pbShiftB (pbShiftB),
  .tmShiftA (tmShiftA)
);

// File: tb/clkdiv_top_tb_top.sv
module clkdiv_top_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rstN;
  logic [15:0] busCfg;
  logic        timMode;
  logic        hsEn;
  logic [1:0]  pbEn;
  logic [1:0]  timEn;
  logic [3:0]  hsShift;
  logic [2:0]  pbShiftA;
  logic [2:0]  pbShiftB;
  logic [3:0]  tmShiftA;
  logic [3:0]  tmShiftB;

  clkdiv_top dut_i (
    .clk(clk), .rstN(rstN), .busCfg(busCfg), .timMode(timMode),
    .hsEn(hsEn), .pbEn(pbEn), .timEn(timEn), .hsShift(hsShift),
    .pbShiftA(pbShiftA), .pbShiftB(pbShiftB),
    .tmShiftA(tmShiftA), .tmShiftB(tmShiftB)
  );

  int    checks = 0;
  int    fails  = 0;
  string tag    = "R7";
  bit    started = 0;
  bit    finished = 0;
  logic [4:0] expQ[$];
  int    left[5];

  // expected shifts written from the requirement text
  function automatic int hsRef(int code);
    case (code)
      8: return 1;   9: return 2;  10: return 3;  11: return 4;
      12: return 6; 13: return 7;  14: return 8;  15: return 9;
      default: return 0;
    endcase
  endfunction

  function automatic int pbRef(int code);
    return (code >= 4) ? code - 3 : 0;
  endfunction

  function automatic int tmRef(int pb, int hs, bit mode);
    if (mode) return (pb <= 2) ? hs : pb - 2;
    return (pb == 0) ? 0 : pb - 1;
  endfunction

  function automatic int expShift(int lane);
    int hs, pa, pb;
    hs = hsRef(int'(busCfg[7:4]));
    pa = pbRef(int'(busCfg[12:10]));
    pb = pbRef(int'(busCfg[15:13]));
    case (lane)
      0: return hs;
      1: return pa;
      2: return pb;
      3: return tmRef(pa, hs, timMode);
      default: return tmRef(pb, hs, timMode);
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // driver side of the scoreboard: one expected enable vector per edge
  always @(posedge clk) begin
    logic [4:0] v;
    started = 1;
    for (int i = 0; i < 5; i++) begin
      if (!rstN)             left[i] = 0;
      else if (left[i] == 0) left[i] = (1 << expShift(i)) - 1;
      else                   left[i] = left[i] - 1;
      v[i] = (left[i] == 0);
    end
    expQ.push_back(v);
  end

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    logic [4:0] v;
    logic [4:0] act;
    if (started && !finished && expQ.size() > 0) begin
      v   = expQ.pop_front();
      act = {timEn, pbEn, hsEn};
      for (int i = 0; i < 5; i++)
        check(act[i] == v[i], $sformatf("%s lane%0d enable", tag, i), int'(act[i]), int'(v[i]));
      check(int'(hsShift) == expShift(0), "R1 hsShift", int'(hsShift), expShift(0));
      check(int'(pbShiftA) == expShift(1), "R2 pbShiftA", int'(pbShiftA), expShift(1));
      check(int'(pbShiftB) == expShift(2), "R2 pbShiftB", int'(pbShiftB), expShift(2));
      check(int'(tmShiftA) == expShift(3), timMode ? "R4 tmShiftA" : "R3 tmShiftA",
            int'(tmShiftA), expShift(3));
      check(int'(tmShiftB) == expShift(4), timMode ? "R4 tmShiftB" : "R3 tmShiftB",
            int'(tmShiftB), expShift(4));
    end
  end

  task automatic apply(logic [15:0] cfg, logic mode, int cycles, string req);
    @(negedge clk);
    #1;
    busCfg  = cfg;
    timMode = mode;
    tag     = req;
    repeat (cycles) @(negedge clk);
  endtask

  function automatic logic [15:0] mkCfg(int hs, int pa, int pb);
    return 16'((pb << 13) | (pa << 10) | (hs << 4));
  endfunction

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    rstN = 1'b0; busCfg = '0; timMode = 1'b0;
    repeat (3) @(negedge clk);
    #1 rstN = 1'b1;               // R7: first cycle after release pulses everywhere
    busCfg = mkCfg(15, 7, 6);
    repeat (3) @(negedge clk);
    tag = "R5";
    apply(16'h0000, 1'b0, 40, "R5");
    for (int c = 0; c < 16; c++)
      apply(mkCfg(c, c % 8, 7 - (c % 8)), c[0], 1100, "R5");
    // R6: long period cut short by a setting change must not shorten it
    apply(mkCfg(15, 7, 7), 1'b1, 100, "R6");
    apply(mkCfg(8, 4, 5), 1'b0, 1200, "R6");
    // R8: high-speed code moves, bus codes fixed
    apply(mkCfg(8, 5, 6), 1'b0, 300, "R8");
    apply(mkCfg(15, 5, 6), 1'b0, 300, "R8");
    apply(mkCfg(3, 5, 6), 1'b0, 300, "R8");
    // R3 / R4 sweep of every bus code in both modes
    for (int m = 0; m < 2; m++)
      for (int p = 0; p < 8; p++)
        apply(mkCfg(9, p, 7 - p), m[0], 70, "R5");
    // R7: reset while lanes are mid-count
    apply(mkCfg(14, 7, 6), 1'b1, 37, "R5");
    @(negedge clk);
    #1 rstN = 1'b0; tag = "R7";
    repeat (2) @(negedge clk);
    #1 rstN = 1'b1;
    repeat (3) @(negedge clk);
    tag = "R5";
    repeat (600) @(negedge clk);
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R5 watchdog actual=running expected=finished");
    summary();
  end
endmodule